// File: doc/BRIEF.md
# Cascaded Reset Tree Generator

This block turns one raw power-good indication and a handful of reset requests into four nested active-low reset trees: power-on, life-cycle, system and module. Each tree is produced for two power domains. Domain 0 is always on. Domain 1 can be switched off.

The power-good input is first synchronized and filtered. A stretch counter then runs, and the power-on root is released only when the counter has finished.

- The life-cycle root follows the power-on root, and it can also be pulled low by a power-manager request.
- The system root follows the life-cycle root, and it can also be pulled low by a power-manager system request or by a debug non-debug-module request.
- The module root follows the system root. A few whitelisted module leaves can additionally be held by software bits.

Every leaf output goes through a two-flop synchronizer on the leaf clock. A leaf asserts at once and releases only after two leaf-clock edges.

The current life-cycle and system root states of each domain are returned to the power manager as status outputs.

Top module: `rst_tree_gen`

## Requirements
- R1: While `pwr_good_i` is low, every reset output is 0 at once. After `pwr_good_i` rises, the power-on root releases after 2+FILT_CYC+STRETCH_CYC `clk_aon_i` edges; with the defaults this is 13 edges. The power-on leaves then follow after two further leaf edges.
- R2: A drop of `pwr_good_i` restarts the whole filter and stretch count from zero, so the release again needs the full count from the new rise.
- R3: `lc_req_i` = 1 forces the life-cycle, system and module outputs of both domains to 0 at once. The power-on outputs are left at 1.
- R4: `sys_req_i` = 1 or `ndm_req_i` = 1 forces the system and module outputs of both domains to 0 at once. The life-cycle outputs are left at 1.
- R5: The module outputs follow the system tree. No output of a tree is 1 while its parent output in the same domain is 0.
- R6: `pd_off_i` = 1 forces the life-cycle, system and module outputs of domain 1 to 0. The power-on output of domain 1 and all outputs of domain 0 are unaffected.
- R7: A bit `sw_rst_i[m]` = 1 holds module leaf m of both domains at 0 for as long as the bit stays 1, but only where SW_ALLOW[m] = 1. The default SW_ALLOW is 3'b101, so leaves 0 and 2 are controllable and leaf 1 ignores its bit. Module output bit d*NUM_MOD+m is leaf m of domain d.
- R8: A leaf output releases only after its root has been high across two consecutive `clk_leaf_i` edges. Assertion does not wait for a clock.
- R9: `lc_src_n_o[d]` and `sys_src_n_o[d]` show the unsynchronized life-cycle and system root state of domain d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon_i | input | 1 | Always-on clock for the power-good filter and stretch counter |
| clk_leaf_i | input | 1 | Leaf clock for the release synchronizers |
| pwr_good_i | input | 1 | Raw root power-good, active high |
| lc_req_i | input | 1 | Power-manager life-cycle reset request |
| sys_req_i | input | 1 | Power-manager system reset request |
| ndm_req_i | input | 1 | Debug non-debug-module reset request |
| pd_off_i | input | 1 | Switchable domain 1 is powered off |
| sw_rst_i | input | NUM_MOD | Software reset bits, one per module leaf |
| rst_por_n_o | output | 2 | Power-on leaf reset per domain |
| rst_lc_n_o | output | 2 | Life-cycle leaf reset per domain |
| rst_sys_n_o | output | 2 | System leaf reset per domain |
| rst_mod_n_o | output | 2*NUM_MOD | Module leaf resets, bit d*NUM_MOD+m |
| lc_src_n_o | output | 2 | Life-cycle root state per domain |
| sys_src_n_o | output | 2 | System root state per domain |

## Verification
Two events can fall in the same cycle: a software bit on a whitelisted module leaf drops, and the system request that also holds that leaf is removed. The bench withdraws both on one drive. The leaf must stay low for one further edge and rise after the second edge, with neither source delaying or shortening the other. A cycle-accurate behavioural model is compared against every output on each clock, so a release one edge early or late is detected anywhere in the run.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int NUM_DOM = 2;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    TREE_POR = 2'd0,
    TREE_LC  = 2'd1,
    TREE_SYS = 2'd2,
    TREE_MOD = 2'd3
  } tree_e;

  // total aon edges from power-good rise to power-on root release
  function automatic int por_release_edges(input int filt, input int stretch);
    return SYNC_STAGES + filt + stretch;
  endfunction

  // flat index of module leaf m in domain d
  function automatic int mod_index(input int d, input int m, input int nmod);
    return d * nmod + m;
  endfunction
endpackage

// File: rtl/rtg_por_filter.sv
module rtg_por_filter #(
  parameter int FILT_CYC    = 3,
  parameter int STRETCH_CYC = 8
) (
  input  logic clk_i,
  input  logic pwr_good_i,
  output logic filt_good_o,
  output logic por_n_o
);
  localparam int FW = $clog2(FILT_CYC + 1);
  localparam int SW = $clog2(STRETCH_CYC + 1);
  localparam logic [FW-1:0] FILT_MAX    = FW'(FILT_CYC);
  localparam logic [SW-1:0] STRETCH_MAX = SW'(STRETCH_CYC);

  logic          sync1_q, sync2_q;
  logic [FW-1:0] filt_cnt_q;
  logic [SW-1:0] str_cnt_q;

  always_ff @(posedge clk_i or negedge pwr_good_i) begin
    if (!pwr_good_i) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk_i or negedge pwr_good_i) begin
    if (!pwr_good_i) begin
      filt_cnt_q <= '0;
    end else if (!sync2_q) begin
      filt_cnt_q <= '0;
    end else if (filt_cnt_q != FILT_MAX) begin
      filt_cnt_q <= filt_cnt_q + 1'b1;
    end
  end

  assign filt_good_o = (filt_cnt_q == FILT_MAX);

  always_ff @(posedge clk_i or negedge pwr_good_i) begin
    if (!pwr_good_i) begin
      str_cnt_q <= '0;
    end else if (!filt_good_o) begin
      str_cnt_q <= '0;
    end else if (str_cnt_q != STRETCH_MAX) begin
      str_cnt_q <= str_cnt_q + 1'b1;
    end
  end

  assign por_n_o = (str_cnt_q == STRETCH_MAX);
endmodule

// File: rtl/rtg_tree_root.sv
module rtg_tree_root #(
  parameter int          NUM_MOD  = 3,
  parameter logic [NUM_MOD-1:0] SW_ALLOW = 3'b101
) (
  input  logic                  por_n_i,
  input  logic                  lc_req_i,
  input  logic                  sys_req_i,
  input  logic                  ndm_req_i,
  input  logic                  pd_off_i,
  input  logic [NUM_MOD-1:0]    sw_rst_i,
  output logic [1:0]            lc_n_o,
  output logic [1:0]            sys_n_o,
  output logic [2*NUM_MOD-1:0]  mod_n_o
);
  import rtg_pkg::*;

  logic [NUM_MOD-1:0] sw_hold;
  assign sw_hold = sw_rst_i & SW_ALLOW;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    logic dom_off;
    if (d == 0) begin : g_aon
      assign dom_off = 1'b0;
    end else begin : g_sw
      assign dom_off = pd_off_i;
    end
    assign lc_n_o[d]  = por_n_i & ~lc_req_i & ~dom_off;
    assign sys_n_o[d] = lc_n_o[d] & ~sys_req_i & ~ndm_req_i;
    for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
      assign mod_n_o[mod_index(d, m, NUM_MOD)] = sys_n_o[d] & ~sw_hold[m];
    end
  end
endmodule

// File: rtl/rtg_leaf_sync.sv
module rtg_leaf_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_no = stage2_q;
endmodule

// File: rtl/rst_tree_gen.sv
module rst_tree_gen #(
  parameter int                 FILT_CYC    = 3,
  parameter int                 STRETCH_CYC = 8,
  parameter int                 NUM_MOD     = 3,
  parameter logic [NUM_MOD-1:0] SW_ALLOW    = 3'b101
) (
  input  logic                 clk_aon_i,
  input  logic                 clk_leaf_i,
  input  logic                 pwr_good_i,
  input  logic                 lc_req_i,
  input  logic                 sys_req_i,
  input  logic                 ndm_req_i,
  input  logic                 pd_off_i,
  input  logic [NUM_MOD-1:0]   sw_rst_i,
  output logic [1:0]           rst_por_n_o,
  output logic [1:0]           rst_lc_n_o,
  output logic [1:0]           rst_sys_n_o,
  output logic [2*NUM_MOD-1:0] rst_mod_n_o,
  output logic [1:0]           lc_src_n_o,
  output logic [1:0]           sys_src_n_o
);
  import rtg_pkg::*;

  localparam int NUM_MOD_LEAF = NUM_DOM * NUM_MOD;

  logic                    filt_good;
  logic                    por_root_n;
  logic [1:0]              lc_root_n;
  logic [1:0]              sys_root_n;
  logic [NUM_MOD_LEAF-1:0] mod_root_n;

  rtg_por_filter #(
    .FILT_CYC   (FILT_CYC),
    .STRETCH_CYC(STRETCH_CYC)
  ) u_filter (
    .clk_i      (clk_aon_i),
    .pwr_good_i (pwr_good_i),
    .filt_good_o(filt_good),
    .por_n_o    (por_root_n)
  );

  rtg_tree_root #(
    .NUM_MOD (NUM_MOD),
    .SW_ALLOW(SW_ALLOW)
  ) u_roots (
    .por_n_i  (por_root_n),
    .lc_req_i (lc_req_i),
    .sys_req_i(sys_req_i),
    .ndm_req_i(ndm_req_i),
    .pd_off_i (pd_off_i),
    .sw_rst_i (sw_rst_i),
    .lc_n_o   (lc_root_n),
    .sys_n_o  (sys_root_n),
    .mod_n_o  (mod_root_n)
  );

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_tree_leaf
    rtg_leaf_sync u_por (.clk_i(clk_leaf_i), .arst_ni(por_root_n),    .rst_no(rst_por_n_o[d]));
    rtg_leaf_sync u_lc  (.clk_i(clk_leaf_i), .arst_ni(lc_root_n[d]),  .rst_no(rst_lc_n_o[d]));
    rtg_leaf_sync u_sys (.clk_i(clk_leaf_i), .arst_ni(sys_root_n[d]), .rst_no(rst_sys_n_o[d]));
  end

  for (genvar k = 0; k < NUM_MOD_LEAF; k++) begin : g_mod_leaf
    rtg_leaf_sync u_mod (.clk_i(clk_leaf_i), .arst_ni(mod_root_n[k]), .rst_no(rst_mod_n_o[k]));
  end

  assign lc_src_n_o  = lc_root_n;
  assign sys_src_n_o = sys_root_n;
endmodule

// File: rtl/rst_tree_gen_chk.sv
module rst_tree_gen_chk #(
  parameter int                 NUM_MOD  = 3,
  parameter logic [NUM_MOD-1:0] SW_ALLOW = 3'b101
) (
  input logic                 clk_leaf_i,
  input logic                 pwr_good_i,
  input logic                 lc_req_i,
  input logic                 sys_req_i,
  input logic                 ndm_req_i,
  input logic                 pd_off_i,
  input logic [NUM_MOD-1:0]   sw_rst_i,
  input logic                 por_root_n,
  input logic [1:0]           rst_por_n_o,
  input logic [1:0]           rst_lc_n_o,
  input logic [1:0]           rst_sys_n_o,
  input logic [2*NUM_MOD-1:0] rst_mod_n_o
);
  for (genvar d = 0; d < 2; d++) begin : g_chk
    // R5
    lc_under_por_chk: assert property (@(posedge clk_leaf_i) disable iff (!pwr_good_i)
      rst_lc_n_o[d] |-> rst_por_n_o[d]);
    // R5
    sys_under_lc_chk: assert property (@(posedge clk_leaf_i) disable iff (!pwr_good_i)
      rst_sys_n_o[d] |-> rst_lc_n_o[d]);
    // R3
    lc_req_holds_chk: assert property (@(posedge clk_leaf_i) disable iff (!pwr_good_i)
      lc_req_i |-> !rst_lc_n_o[d]);
    // R4
    sys_req_holds_chk: assert property (@(posedge clk_leaf_i) disable iff (!pwr_good_i)
      (ndm_req_i || sys_req_i) |-> !rst_sys_n_o[d]);
  end

  // R6
  pd_off_holds_chk: assert property (@(posedge clk_leaf_i) disable iff (!pwr_good_i)
    pd_off_i |-> !rst_lc_n_o[1]);

  // R8
  por_release_sync_chk: assert property (@(posedge clk_leaf_i) disable iff (!pwr_good_i)
    $rose(rst_por_n_o[0]) |-> ($past(por_root_n) && $past(por_root_n, 2)));

  for (genvar m = 0; m < NUM_MOD; m++) begin : g_sw
    if (SW_ALLOW[m]) begin : g_on
      // R7
      sw_hold_chk: assert property (@(posedge clk_leaf_i) disable iff (!pwr_good_i)
        sw_rst_i[m] |-> !rst_mod_n_o[m]);
    end
  end
endmodule

bind rst_tree_gen rst_tree_gen_chk #(.NUM_MOD(NUM_MOD), .SW_ALLOW(SW_ALLOW)) u_chk (
  .clk_leaf_i (clk_leaf_i),
  .pwr_good_i (pwr_good_i),
  .lc_req_i   (lc_req_i),
  .sys_req_i  (sys_req_i),
  .ndm_req_i  (ndm_req_i),
  .pd_off_i   (pd_off_i),
  .sw_rst_i   (sw_rst_i),
  .por_root_n (por_root_n),
  .rst_por_n_o(rst_por_n_o),
  .rst_lc_n_o (rst_lc_n_o),
  .rst_sys_n_o(rst_sys_n_o),
  .rst_mod_n_o(rst_mod_n_o)
);

// File: tb/test_rst_tree_gen.sv
`timescale 1ns/1ps
module test_rst_tree_gen;
  localparam int F = 3;
  localparam int S = 8;
  localparam int NM = 3;
  localparam int T = 2 + F + S;
  localparam int NL = 6 + 2 * NM;
  localparam logic [NM-1:0] ALLOW = 3'b101;

  logic clk = 1'b0;
  logic pwr_good = 1'b0, lc_req = 1'b0, sys_req = 1'b0, ndm_req = 1'b0, pd_off = 1'b0;
  logic [NM-1:0] sw = '0;
  logic [1:0] por_o, lc_o, sys_o, lcs_o, syss_o;
  logic [2*NM-1:0] mod_o;

  int checks = 0, failures = 0, cyc = 0;
  int pcnt = 0;
  int lcnt [NL];
  bit done = 0;

  always #2.5 clk = ~clk;

  rst_tree_gen #(.FILT_CYC(F), .STRETCH_CYC(S), .NUM_MOD(NM), .SW_ALLOW(ALLOW)) i_rst_tree_gen (
    .clk_aon_i(clk), .clk_leaf_i(clk), .pwr_good_i(pwr_good), .lc_req_i(lc_req),
    .sys_req_i(sys_req), .ndm_req_i(ndm_req), .pd_off_i(pd_off), .sw_rst_i(sw),
    .rst_por_n_o(por_o), .rst_lc_n_o(lc_o), .rst_sys_n_o(sys_o), .rst_mod_n_o(mod_o),
    .lc_src_n_o(lcs_o), .sys_src_n_o(syss_o));

  // leaf numbering: 0..1 por, 2..3 lc, 4..5 sys, 6.. module (domain-major)
  function automatic bit model_root(int leaf, int p);
    bit por, lc, sys;
    int dom, m;
    por = pwr_good && (p >= T);
    if (leaf < 2) return por;
    dom = (leaf < 6) ? (leaf % 2) : ((leaf - 6) / NM);
    lc = por && !lc_req && !(dom == 1 && pd_off);
    if (leaf < 4) return lc;
    sys = lc && !sys_req && !ndm_req;
    if (leaf < 6) return sys;
    m = (leaf - 6) % NM;
    return sys && !(ALLOW[m] && sw[m]);
  endfunction

  function automatic bit actual(int leaf);
    if (leaf < 2) return por_o[leaf];
    if (leaf < 4) return lc_o[leaf-2];
    if (leaf < 6) return sys_o[leaf-4];
    return mod_o[leaf-6];
  endfunction

  function automatic string tag_of(int leaf);
    if (leaf < 2) return "R1";
    if (leaf < 4) return "R3";
    if (leaf < 6) return "R4";
    return "R5";
  endfunction

  task automatic check(input bit act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    for (int l = 0; l < NL; l++) begin
      if (!model_root(l, pcnt)) lcnt[l] = 0;
      else if (lcnt[l] < 2) lcnt[l] = lcnt[l] + 1;
    end
    if (!pwr_good) pcnt = 0;
    else if (pcnt < T) pcnt = pcnt + 1;
  end

  always @(negedge clk) begin
    int p;
    p = pwr_good ? pcnt : 0;
    for (int l = 0; l < NL; l++)
      check(actual(l), model_root(l, p) && lcnt[l] >= 2, $sformatf("%s leaf %0d", tag_of(l), l));
    for (int d = 0; d < 2; d++) begin
      check(lcs_o[d], model_root(2 + d, p), $sformatf("R9 lc status dom %0d", d));
      check(syss_o[d], model_root(4 + d, p), $sformatf("R9 sys status dom %0d", d));
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    for (int l = 0; l < NL; l++) lcnt[l] = 0;
    step(3);
    // R1: held while power-good is low
    check(por_o[0] | por_o[1] | lc_o[0] | sys_o[1] | mod_o[0], 1'b0, "R1 all low in reset");
    pwr_good = 1'b1;
    step(T + 1);
    check(por_o[0], 1'b0, "R1 por still low before sync");
    step(1);
    check(por_o[0], 1'b1, "R1 por released after count plus sync");
    // R2: dip restarts count
    pwr_good = 1'b0;
    #0.5 check(por_o[1], 1'b0, "R1 async assert on power-good drop");
    step(1);
    pwr_good = 1'b1;
    step(8);
    pwr_good = 1'b0;
    step(1);
    pwr_good = 1'b1;
    step(T);
    check(por_o[0], 1'b0, "R2 restart after dip");
    step(4);
    check(por_o[0], 1'b1, "R2 released after full recount");
    // R3
    lc_req = 1'b1;
    #0.5;
    check(lc_o[0] | lc_o[1] | sys_o[0] | mod_o[4], 1'b0, "R3 lc request asserts children");
    check(por_o[0] & por_o[1], 1'b1, "R3 power-on untouched");
    step(3);
    lc_req = 1'b0;
    step(4);
    // R4
    ndm_req = 1'b1;
    #0.5;
    check(sys_o[0] | sys_o[1] | mod_o[2], 1'b0, "R4 ndm asserts system");
    check(lc_o[0] & lc_o[1], 1'b1, "R4 lc untouched");
    step(2);
    ndm_req = 1'b0;
    sys_req = 1'b1;
    step(2);
    check(sys_o[1], 1'b0, "R4 sys request asserts system");
    sys_req = 1'b0;
    step(4);
    // R6
    pd_off = 1'b1;
    #0.5;
    check(lc_o[1] | sys_o[1] | mod_o[3] | mod_o[5], 1'b0, "R6 domain 1 held");
    check(lc_o[0] & sys_o[0] & mod_o[0] & por_o[1], 1'b1, "R6 domain 0 and por unaffected");
    step(3);
    pd_off = 1'b0;
    step(4);
    // R7
    sw = 3'b111;
    step(5);
    check(mod_o[0] | mod_o[2] | mod_o[3] | mod_o[5], 1'b0, "R7 allowed leaves held");
    check(mod_o[1] & mod_o[4], 1'b1, "R7 leaf 1 ignores software");
    // same cycle: sw release of leaf 0 together with system request release
    sys_req = 1'b1;
    step(2);
    sw = 3'b110;
    sys_req = 1'b0;
    step(1);
    check(mod_o[0], 1'b0, "R8 low after one edge");
    step(1);
    check(mod_o[0], 1'b1, "R8 released after two edges");
    check(mod_o[2], 1'b0, "R7 leaf 2 still held");
    sw = 3'b000;
    step(3);
    check(mod_o[2], 1'b1, "R7 leaf 2 released");
    step(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule